// File: doc/BRIEF.md
# Random Permutation Order Generator

This block turns a word of random control bits into a processing schedule for the sixteen bytes of a 128-bit cipher state. The fixed indices 0 through 15 enter a network of 2x2 switches. Each switch is a pair of 2:1 multiplexers that share one control bit. The network's outputs are therefore always some rearrangement of those indices. The whole rearrangement settles combinationally, so a complete schedule is produced in one clock cycle.

A single strobe captures the network output into a sixteen-entry order memory and marks the memory as holding a fresh schedule. A sequencing controller then presents one step number per cycle and reads the byte index for that step back combinationally.

A build parameter selects the network. The default is a rearrangeable Benes network with 56 switches, which can reach every one of the 16! orderings. The alternative is an Omega network with 32 switches, which costs less and reaches at most 2^32 orderings. The random source is outside the block.

Top module: `perm_order_gen`

## Requirements
- R1: After a synchronous active-low reset, `valid_o` is 0 and the order memory holds the identity order: reading step s returns s.
- R2: When `gen_i` is 1 at a rising clock edge, all sixteen network outputs are written into the order memory on that edge. From then on, `valid_o` reads 1.
- R3: For every control word, the sixteen values held in the order memory, and the sixteen values at the network output, contain each index 0 to 15 exactly once.
- R4: A switch with control bit 0 passes its upper input to its upper output. A switch with control bit 1 swaps its two inputs. Stage s (counted from the input side, starting at 0) switch k takes control bit `s*8 + k`. Switch k of a stage joins positions 2k (upper) and 2k+1 (lower).
- R5: In the Benes build, `ctrl_i` is 56 bits wide and there are seven stages. Before stage 0, port j carries the constant j. After stages 0, 1 and 2 the wiring works in blocks of size 16, 8 and 4 respectively. Within a block, local position 2k+p moves to local position p*B/2+k, where B is the block size. After stages 3, 4 and 5 the inverse mapping is applied, in blocks of size 4, 8 and 16. Output position j of stage 6 becomes order entry j.
- R6: A control word of all zeros yields the identity order in both builds.
- R7: `order_o` shows entry `step_i` of the order memory in the same cycle, with no clock edge needed.
- R8: While `gen_i` is 0, changes on `ctrl_i` leave every stored entry and `valid_o` unchanged.
- R9: In the Omega build, `ctrl_i` is 32 bits wide and there are four stages. Before each stage, a perfect shuffle sends position j to position ((j<<1) | (j>>3)) mod 16. Output position j of stage 3 becomes order entry j.
- R10: Once set, `valid_o` stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous active-low reset |
| gen_i | input | 1 | Capture strobe: stores a new order from `ctrl_i` |
| ctrl_i | input | CTRL_W (56 Benes, 32 Omega) | Random switch control bits |
| step_i | input | 4 | Step number to read |
| order_o | output | 4 | Byte index scheduled at `step_i` |
| valid_o | output | 1 | A generated order is held |

## Verification
If a switch were wired wrongly or took the wrong control bit, the stored order would differ from the reference model at the very first capture with a suitable control word. A missing or duplicated value would show up in the seen-mask once all sixteen steps of that capture had been read. A write path that leaked while the strobe was low would show up as a changed entry when the schedule was re-read a few cycles after `ctrl_i` moved. A fault in the reset value would be visible on `order_o` and `valid_o` in the first cycle after reset.

// File: rtl/perm_pkg.sv
// Shared definitions for the permutation order generator.
// Assumes the port count is a power of two, no smaller than 2.
package perm_pkg;

    typedef enum logic {
        TOPO_BENES = 1'b0,
        TOPO_OMEGA = 1'b1
    } topo_e;

    // Number of switch columns for a topology at a given port count
    function automatic int stage_count(topo_e topo, int n);
        int lg;
        lg = $clog2(n);
        return (topo == TOPO_BENES) ? (2 * lg - 1) : lg;
    endfunction

    // Number of control bits: one per switch
    function automatic int ctrl_bits(topo_e topo, int n);
        return (n / 2) * stage_count(topo, n);
    endfunction

endpackage

// File: rtl/perm_xbar2.sv
// 2x2 switch: two 2:1 multiplexers that share one select.
// Assumes nothing beyond a common data width on both inputs.
module perm_xbar2 #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cross_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);

    // Upper and lower output multiplexers
    assign a_o = cross_i ? b_i : a_i;
    assign b_o = cross_i ? a_i : b_i;

endmodule

// File: rtl/perm_benes_net.sv
// Rearrangeable Benes network, flattened from its recursive form.
// Forward stages send the upper switch output to the upper half of the
// current block and the lower output to the lower half. Mirror stages
// undo that. Bit s*N/2+k drives switch k of stage s.
// Assumes N is a power of two.
module perm_benes_net #(
    parameter int N  = 16,
    parameter int W  = 4,
    localparam int LG     = $clog2(N),
    localparam int STAGES = 2 * LG - 1,
    localparam int HALF   = N / 2,
    localparam int CW     = HALF * STAGES
) (
    input  logic [N-1:0][W-1:0] in_i,
    input  logic [CW-1:0]       ctrl_i,
    output logic [N-1:0][W-1:0] out_o
);

    logic [W-1:0] sw_in  [STAGES][N];
    logic [W-1:0] sw_out [STAGES][N];

    for (genvar j = 0; j < N; j++) begin : g_edge
        // Network input and output ports
        assign sw_in[0][j] = in_i[j];
        assign out_o[j]    = sw_out[STAGES-1][j];
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar k = 0; k < HALF; k++) begin : g_sw
            perm_xbar2 #(.W(W)) u_sw (
                .a_i    (sw_in[s][2*k]),
                .b_i    (sw_in[s][2*k+1]),
                .cross_i(ctrl_i[s*HALF+k]),
                .a_o    (sw_out[s][2*k]),
                .b_o    (sw_out[s][2*k+1])
            );
        end
        if (s < STAGES - 1) begin : g_link
            localparam int BLK = (s < LG - 1) ? (N >> s) : (N >> (2*LG - 3 - s));
            for (genvar j = 0; j < N; j++) begin : g_wire
                localparam int BASE = (j / BLK) * BLK;
                localparam int LOC  = j % BLK;
                localparam int DST  = BASE + (LOC % 2) * (BLK / 2) + LOC / 2;
                if (s < LG - 1) begin : g_fwd
                    // Split into upper and lower sub-networks
                    assign sw_in[s+1][DST] = sw_out[s][j];
                end else begin : g_rev
                    // Merge sub-networks back into switch pairs
                    assign sw_in[s+1][j] = sw_out[s][DST];
                end
            end
        end
    end

endmodule

// File: rtl/perm_omega_net.sv
// Omega network: a perfect shuffle ahead of each of log2(N) switch
// columns. Bit s*N/2+k drives switch k of stage s.
// Assumes N is a power of two.
module perm_omega_net #(
    parameter int N  = 16,
    parameter int W  = 4,
    localparam int LG     = $clog2(N),
    localparam int STAGES = LG,
    localparam int HALF   = N / 2,
    localparam int CW     = HALF * STAGES
) (
    input  logic [N-1:0][W-1:0] in_i,
    input  logic [CW-1:0]       ctrl_i,
    output logic [N-1:0][W-1:0] out_o
);

    logic [W-1:0] sw_in  [STAGES][N];
    logic [W-1:0] sw_out [STAGES][N];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar j = 0; j < N; j++) begin : g_shuf
            localparam int ROT = ((j << 1) | (j >> (LG - 1))) & (N - 1);
            if (s == 0) begin : g_first
                // Shuffle the constant inputs into stage 0
                assign sw_in[0][ROT] = in_i[j];
            end else begin : g_mid
                // Shuffle the previous column into this one
                assign sw_in[s][ROT] = sw_out[s-1][j];
            end
        end
        for (genvar k = 0; k < HALF; k++) begin : g_sw
            perm_xbar2 #(.W(W)) u_sw (
                .a_i    (sw_in[s][2*k]),
                .b_i    (sw_in[s][2*k+1]),
                .cross_i(ctrl_i[s*HALF+k]),
                .a_o    (sw_out[s][2*k]),
                .b_o    (sw_out[s][2*k+1])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_out
        // Last column feeds the output directly
        assign out_o[j] = sw_out[STAGES-1][j];
    end

endmodule

// File: rtl/perm_order_mem.sv
// Order memory: captures a full N-entry schedule on one edge and offers
// a combinational read port. Resets to the identity schedule.
// Assumes N = 2**W.
module perm_order_mem #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [N-1:0][W-1:0] data_i,
    input  logic [W-1:0]       raddr_i,
    output logic [W-1:0]       rdata_o,
    output logic               valid_o
);

    logic [N-1:0][W-1:0] mem_q;
    logic                valid_q;
    logic [N-1:0]        seen;

    // Capture the whole schedule, or restore identity on reset
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < N; i++) mem_q[i] <= W'(i);
            valid_q <= 1'b0;
        end else if (wr_i) begin
            mem_q   <= data_i;
            valid_q <= 1'b1;
        end
    end

    // Combinational read port
    assign rdata_o = mem_q[raddr_i];
    assign valid_o = valid_q;

    // Coverage mask of stored entries, used by the checks below
    always_comb begin
        seen = '0;
        for (int i = 0; i < N; i++) seen[mem_q[i]] = 1'b1;
    end

    AST_VALID_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_i |=> valid_o); // R2
    AST_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_i |=> $stable(mem_q) && $stable(valid_o)); // R8
    AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(valid_o) |-> $past(!rst_ni)); // R10
    AST_MEM_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_o |-> (seen == '1)); // R3

endmodule

// File: rtl/perm_order_gen.sv
// Top: feeds the constants 0..N-1 through the selected switch network
// and stores the result in the order memory when gen_i is high.
// Assumes ctrl_i comes from an external random source.
module perm_order_gen #(
    parameter int             N        = 16,
    parameter perm_pkg::topo_e TOPOLOGY = perm_pkg::TOPO_BENES,
    localparam int IDX_W  = $clog2(N),
    localparam int CTRL_W = perm_pkg::ctrl_bits(TOPOLOGY, N)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              gen_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [IDX_W-1:0]  step_i,
    output logic [IDX_W-1:0]  order_o,
    output logic              valid_o
);

    logic [N-1:0][IDX_W-1:0] net_in;
    logic [N-1:0][IDX_W-1:0] net_out;
    logic [N-1:0]            net_seen;

    for (genvar j = 0; j < N; j++) begin : g_const
        // Fixed index fed to each network port
        assign net_in[j] = IDX_W'(j);
    end

    if (TOPOLOGY == perm_pkg::TOPO_BENES) begin : g_benes
        perm_benes_net #(.N(N), .W(IDX_W)) u_net (
            .in_i  (net_in),
            .ctrl_i(ctrl_i),
            .out_o (net_out)
        );
    end else begin : g_omega
        perm_omega_net #(.N(N), .W(IDX_W)) u_net (
            .in_i  (net_in),
            .ctrl_i(ctrl_i),
            .out_o (net_out)
        );
    end

    perm_order_mem #(.N(N), .W(IDX_W)) u_mem (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (gen_i),
        .data_i (net_out),
        .raddr_i(step_i),
        .rdata_o(order_o),
        .valid_o(valid_o)
    );

    // Coverage mask of the network output
    always_comb begin
        net_seen = '0;
        for (int i = 0; i < N; i++) net_seen[net_out[i]] = 1'b1;
    end

    AST_NET_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni) gen_i |-> (net_seen == '1)); // R3

endmodule

// File: tb/perm_order_gen_tb_top.sv
// Scoreboard bench: a driver task pushes modelled orders, a monitor
// task pops them and reads every step from both network builds.
module perm_order_gen_tb_top;

    typedef logic [15:0][3:0] ord_t;
    typedef struct {
        ord_t ben;
        ord_t omg;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen = 1'b0;
    logic [55:0] ctrl_b = '0;
    logic [31:0] ctrl_o = '0;
    logic [3:0]  step = '0;
    logic [3:0]  ord_b, ord_o;
    logic        val_b, val_o;

    int total = 0;
    int bad = 0;
    item_t sb_q[$];
    item_t last_item;

    always #4 clk = ~clk;

    perm_order_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .gen_i(gen), .ctrl_i(ctrl_b),
        .step_i(step), .order_o(ord_b), .valid_o(val_b)
    );

    perm_order_gen #(.TOPOLOGY(perm_pkg::TOPO_OMEGA)) dut_om_i (
        .clk_i(clk), .rst_ni(rst_n), .gen_i(gen), .ctrl_i(ctrl_o),
        .step_i(step), .order_o(ord_o), .valid_o(val_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model from R4/R5: straight/cross switches, split then merge wiring
    function automatic ord_t model_benes(input logic [55:0] c);
        ord_t cur, nxt;
        int blk, loc, base, d;
        for (int j = 0; j < 16; j++) cur[j] = 4'(j);
        for (int s = 0; s < 7; s++) begin
            for (int k = 0; k < 8; k++)
                if (c[s*8+k]) begin
                    nxt[0] = cur[2*k];
                    cur[2*k] = cur[2*k+1];
                    cur[2*k+1] = nxt[0];
                end
            if (s < 6) begin
                blk = (s < 3) ? (16 >> s) : (16 >> (5 - s));
                for (int j = 0; j < 16; j++) begin
                    base = (j / blk) * blk;
                    loc = j % blk;
                    d = base + (loc % 2) * (blk / 2) + loc / 2;
                    if (s < 3) nxt[d] = cur[j];
                    else nxt[j] = cur[d];
                end
                cur = nxt;
            end
        end
        return cur;
    endfunction

    // Model from R4/R9: perfect shuffle ahead of each column
    function automatic ord_t model_omega(input logic [31:0] c);
        ord_t cur, nxt;
        logic [3:0] tmp;
        for (int j = 0; j < 16; j++) cur[j] = 4'(j);
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 16; j++) nxt[((j << 1) | (j >> 3)) & 15] = cur[j];
            cur = nxt;
            for (int k = 0; k < 8; k++)
                if (c[s*8+k]) begin
                    tmp = cur[2*k];
                    cur[2*k] = cur[2*k+1];
                    cur[2*k+1] = tmp;
                end
        end
        return cur;
    endfunction

    // Driver: strobe a new order and push its expected contents
    task automatic drive_gen(input logic [55:0] cb, input logic [31:0] co);
        item_t it;
        @(negedge clk);
        ctrl_b = cb;
        ctrl_o = co;
        gen = 1'b1;
        it.ben = model_benes(cb);
        it.omg = model_omega(co);
        sb_q.push_back(it);
        last_item = it;
        @(negedge clk);
        gen = 1'b0;
    endtask

    // Monitor: pop an expected order and read all steps combinationally
    task automatic monitor_pop();
        item_t it;
        logic [15:0] mb, mo;
        it = sb_q.pop_front();
        mb = '0;
        mo = '0;
        check(val_b === 1'b1, "R2 benes valid", int'(val_b), 1);
        check(val_o === 1'b1, "R2 omega valid", int'(val_o), 1);
        for (int st = 0; st < 16; st++) begin
            step = 4'(st);
            #1;
            check(ord_b === it.ben[st], "R5 R7 benes entry", int'(ord_b), int'(it.ben[st]));
            check(ord_o === it.omg[st], "R9 R7 omega entry", int'(ord_o), int'(it.omg[st]));
            mb[ord_b] = 1'b1;
            mo[ord_o] = 1'b1;
        end
        check(mb == 16'hFFFF, "R3 benes coverage", int'(mb), 16'hFFFF);
        check(mo == 16'hFFFF, "R3 omega coverage", int'(mo), 16'hFFFF);
    endtask

    task automatic check_identity(input string req);
        for (int st = 0; st < 16; st++) begin
            step = 4'(st);
            #1;
            check(ord_b === 4'(st), req, int'(ord_b), st);
            check(ord_o === 4'(st), req, int'(ord_o), st);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(val_b === 1'b0, "R1 benes valid after reset", int'(val_b), 0);
        check(val_o === 1'b0, "R1 omega valid after reset", int'(val_o), 0);
        check_identity("R1 identity after reset");

        // R6: all-zero controls give identity
        drive_gen('0, '0);
        check_identity("R6 zero control identity");
        monitor_pop();

        // R4: all-ones and single-bit patterns
        drive_gen({56{1'b1}}, {32{1'b1}});
        monitor_pop();
        for (int b = 0; b < 56; b += 5) begin
            drive_gen(56'(1) << b, 32'(1) << (b % 32));
            monitor_pop();
        end

        // R3/R5/R9: random control words
        for (int n = 0; n < 200; n++) begin
            drive_gen({$urandom(), $urandom()} >> 8, $urandom());
            monitor_pop();
        end

        // R8/R10: control changes without strobe leave order and valid alone
        drive_gen({$urandom(), $urandom()} >> 8, $urandom());
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            ctrl_b = {$urandom(), $urandom()} >> 8;
            ctrl_o = $urandom();
        end
        monitor_pop();
        sb_q.push_back(last_item);
        repeat (5) @(negedge clk);
        check(val_b === 1'b1, "R10 benes valid held", int'(val_b), 1);
        monitor_pop();

        // R1: reset after use restores identity and clears valid
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(val_b === 1'b0, "R1 benes valid cleared", int'(val_b), 0);
        check(val_o === 1'b0, "R1 omega valid cleared", int'(val_o), 0);
        check_identity("R1 identity after second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule